// File: doc/BRIEF.md
# Real-Time Clock Host Register Front End

This block sits between a narrow host bus and the register space of a real-time clock. The host sees only two byte locations. A write to the even location picks one of 128 byte slots. A read or write at the odd location then reaches that slot. Most slots are plain storage. The three time bytes (seconds, minutes, hours) are also reloaded from the calendar block at the end of each update cycle. Four slots hold control and status, and each of them has its own access rule.

The calendar block supplies two strobes: one that opens an update cycle and one that closes it. With the closing strobe it also sends the new time values. A separate divider supplies a periodic strobe. From these events the block builds the status flags and drives one interrupt line. The host acknowledges the interrupt by reading the status byte. The same read clears every pending flag. At the end of each update cycle the block compares the new time against three alarm bytes. An alarm byte whose top two bits are both set matches any value.

Top module: `rtc_host_regs`

## Requirements
- R1: A write with `host_addr`=0 stores bits 6:0 of `host_wdata` as the slot index, and bit 7 is ignored. Later accesses with `host_addr`=1 reach that slot.
- R2: Storage slots read back exactly what was last written. Storage slots are every slot except 0x0A–0x0D, and include the alarm bytes 0x01, 0x03 and 0x05. `host_rdata` is valid in the cycle after the read strobe.
- R3: Bit 7 of the control byte at 0x0A (update busy) cannot be written. A host write to 0x0A changes only bits 6:0.
- R4: The status byte at 0x0C and the fixed byte at 0x0D ignore host writes. 0x0D always reads 0x80.
- R5: `upd_start` sets the busy bit when bit 7 of the mode byte 0x0B (freeze) is clear. `upd_done` clears the busy bit.
- R6: Writing 0x0B with bit 7 set clears the busy bit at once. While freeze is set, `upd_start` does not set the busy bit, and `upd_done` does not reload the time slots 0x00/0x02/0x04. While freeze is clear, `upd_done` loads `upd_sec`, `upd_min` and `upd_hr` into those slots.
- R7: Every `upd_done` sets status bit 4. If bit 4 of 0x0B is set, it also sets status bit 7 and raises `irq`.
- R8: At `upd_done`, suppose bit 5 of 0x0B is set and each alarm byte (0x01 vs seconds, 0x03 vs minutes, 0x05 vs hours) either equals the new time byte or has bits 7:6 = 11. Then status bits 7 and 5 are set and `irq` rises. A single mismatching field prevents this.
- R9: `per_tick` sets status bits 7 and 6 and raises `irq` only when bit 6 of 0x0B is set. Otherwise it has no effect.
- R10: A read of 0x0C returns the flags, then clears the status byte and lowers `irq`. A flag that is set in the same cycle as the read survives.
- R11: After `rst_n` is low, 0x0A=0x26, 0x0B=0x02, 0x0C=0x00, 0x0D=0x80, and `irq`=0.
- R12: A `sys_clr` pulse clears bits 6, 5 and 3 of 0x0B, clears the status byte and lowers `irq`. All other bytes are left unchanged.
- R13: A read with `host_addr`=0 returns 0xFF.
- R14: `irq` always equals status bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| sys_clr | input | 1 | System reset pulse that clears the enables and flags |
| host_addr | input | 1 | 0 = index location, 1 = data location |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| upd_start | input | 1 | Update cycle begins |
| upd_done | input | 1 | Update cycle ends; new time valid |
| upd_sec | input | 8 | New seconds value |
| upd_min | input | 8 | New minutes value |
| upd_hr | input | 8 | New hours value |
| per_tick | input | 1 | Periodic strobe |
| host_rdata | output | 8 | Read data, registered |
| irq | output | 1 | Interrupt request, active high |

## Verification
The alarm comparison is exercised with three inputs. The first is a full match in which the seconds field is a wildcard. The second differs from it in the minutes field only, which separates a real per-field compare from a compare that ignores fields. The third is a full match with the alarm enable off. The update strobes are sent with freeze clear and with freeze set. This tells a correct load inhibit apart from a busy bit that only tracks writes. The status byte is read twice in a row, which exposes both a missing clear and a flag that is lost.

// File: rtl/rtc_host_pkg.sv
// Package: shared constants for the clock register front end.
// Assumes an 8-bit data path and a slot space of at least 16 bytes.
package rtc_host_pkg;
    localparam int DATA_W = 8;

    // Slot offsets that the host software decodes
    localparam int OFS_SEC  = 0;
    localparam int OFS_ASEC = 1;
    localparam int OFS_MIN  = 2;
    localparam int OFS_AMIN = 3;
    localparam int OFS_HR   = 4;
    localparam int OFS_AHR  = 5;
    localparam int OFS_CTLA = 10;
    localparam int OFS_MODE = 11;
    localparam int OFS_STAT = 12;
    localparam int OFS_FIX  = 13;

    // Power-on values
    localparam logic [DATA_W-1:0] RST_CTLA = 8'h26;
    localparam logic [DATA_W-1:0] RST_MODE = 8'h02;
    localparam logic [DATA_W-1:0] RST_STAT = 8'h00;
    localparam logic [DATA_W-1:0] FIX_VAL  = 8'h80;
    localparam logic [DATA_W-1:0] IDX_READ = 8'hFF;

    // Bit positions
    localparam int A_BUSY   = 7;
    localparam int M_FREEZE = 7;
    localparam int M_PER_EN = 6;
    localparam int M_ALM_EN = 5;
    localparam int M_UPD_EN = 4;
    localparam int M_SQW_EN = 3;
    localparam int S_IRQ    = 7;
    localparam int S_PER    = 6;
    localparam int S_ALM    = 5;
    localparam int S_UPD    = 4;

    // Alarm wildcard code in bits 7:6
    localparam logic [1:0] ALM_ANY = 2'b11;

    typedef enum logic [2:0] {
        SEL_RAM,
        SEL_CTLA,
        SEL_MODE,
        SEL_STAT,
        SEL_FIX
    } slot_sel_t;
endpackage

// File: rtl/rtc_host_index.sv
// Index latch and slot decoder.
// Holds the slot index written at the even location and classifies it.
// Assumes the index is IDX_W bits wide, taken from the low data bits.
module rtc_host_index
    import rtc_host_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idx_we,
    input  logic [IDX_W-1:0] idx_in,
    output logic [IDX_W-1:0] idx,
    output slot_sel_t        sel
);
    // Latch a new index on an even-location write
    always_ff @(posedge clk) begin
        if (!rst_n)      idx <= '0;
        else if (idx_we) idx <= idx_in;
    end

    // Classify the current slot
    always_comb begin
        sel = SEL_RAM;
        if      (idx == IDX_W'(OFS_CTLA)) sel = SEL_CTLA;
        else if (idx == IDX_W'(OFS_MODE)) sel = SEL_MODE;
        else if (idx == IDX_W'(OFS_STAT)) sel = SEL_STAT;
        else if (idx == IDX_W'(OFS_FIX))  sel = SEL_FIX;
    end

    // Index stays within the slot space
    p_idx_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        idx_we |=> idx == $past(idx_in));
endmodule

// File: rtl/rtc_host_ram.sv
// Byte storage for every slot that is not a control byte.
// Time slots are also loaded from the calendar; in the same cycle a host write wins.
// Assumes BYTES is large enough to hold the time and alarm offsets.
module rtc_host_ram
    import rtc_host_pkg::*;
#(
    parameter int BYTES = 128,
    parameter int IDX_W = $clog2(BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ld_en,
    input  logic [DATA_W-1:0] ld_sec,
    input  logic [DATA_W-1:0] ld_min,
    input  logic [DATA_W-1:0] ld_hr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_byte,
    output logic [2:0][DATA_W-1:0] alarm_bytes
);
    logic [DATA_W-1:0] mem [BYTES];

    // Calendar reload first, host write last so that the host wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < BYTES; i++) mem[i] <= '0;
        end else begin
            if (ld_en) begin
                mem[OFS_SEC] <= ld_sec;
                mem[OFS_MIN] <= ld_min;
                mem[OFS_HR]  <= ld_hr;
            end
            if (wr_en) mem[wr_idx] <= wr_data;
        end
    end

    // Read ports for the host and the alarm comparator
    always_comb begin
        rd_byte        = mem[rd_idx];
        alarm_bytes[0] = mem[OFS_ASEC];
        alarm_bytes[1] = mem[OFS_AMIN];
        alarm_bytes[2] = mem[OFS_AHR];
    end

    // A loaded seconds slot holds the calendar value
    p_load_sec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en && !(wr_en && wr_idx == IDX_W'(OFS_SEC)) |=> mem[OFS_SEC] == $past(ld_sec));
endmodule

// File: rtl/rtc_alarm_match.sv
// Per-field alarm comparator with a wildcard code in the top two bits.
// Assumes the alarm and time bytes use the same encoding.
module rtc_alarm_match
    import rtc_host_pkg::*;
#(
    parameter int FIELDS = 3
) (
    input  logic [FIELDS-1:0][DATA_W-1:0] alarm,
    input  logic [FIELDS-1:0][DATA_W-1:0] now,
    output logic                          hit
);
    logic [FIELDS-1:0] field_ok;

    // One comparator per field
    for (genvar g = 0; g < FIELDS; g++) begin : g_field
        assign field_ok[g] = (alarm[g][DATA_W-1:DATA_W-2] == ALM_ANY) ||
                             (alarm[g] == now[g]);
    end

    // All fields must agree
    assign hit = &field_ok;
endmodule

// File: rtl/rtc_host_ctrl.sv
// Control, mode and status bytes and the interrupt line.
// Assumes strobes are single-cycle; sys_clr overrides every other event.
module rtc_host_ctrl
    import rtc_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_clr,
    input  logic              wr_ctla,
    input  logic              wr_mode,
    input  logic              rd_stat,
    input  logic [DATA_W-1:0] wdata,
    input  logic              upd_start,
    input  logic              upd_done,
    input  logic              per_tick,
    input  logic              alarm_hit,
    output logic [DATA_W-1:0] reg_ctla,
    output logic [DATA_W-1:0] reg_mode,
    output logic [DATA_W-1:0] reg_stat,
    output logic [DATA_W-1:0] reg_fix,
    output logic              irq
);
    logic [DATA_W-2:0] ctla_low;
    logic              busy;
    logic [DATA_W-1:0] mode_q;
    logic [DATA_W-1:0] stat_q;
    logic [DATA_W-1:0] stat_set;
    logic [DATA_W-1:0] mode_clr_mask;

    assign mode_clr_mask = ~((DATA_W'(1) << M_PER_EN) |
                             (DATA_W'(1) << M_ALM_EN) |
                             (DATA_W'(1) << M_SQW_EN));

    // Writable low bits of the control byte
    always_ff @(posedge clk) begin
        if (!rst_n)       ctla_low <= RST_CTLA[DATA_W-2:0];
        else if (wr_ctla) ctla_low <= wdata[DATA_W-2:0];
    end

    // Busy flag: cleared by freeze or end of update, set at start
    always_ff @(posedge clk) begin
        if (!rst_n)                          busy <= RST_CTLA[A_BUSY];
        else if (wr_mode && wdata[M_FREEZE]) busy <= 1'b0;
        else if (upd_done)                   busy <= 1'b0;
        else if (upd_start && !mode_q[M_FREEZE]) busy <= 1'b1;
    end

    // Mode byte: host write, enables dropped by system reset
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= RST_MODE;
        else if (sys_clr) mode_q <= mode_q & mode_clr_mask;
        else if (wr_mode) mode_q <= wdata;
    end

    // Flags raised by this cycle's events
    always_comb begin
        stat_set = '0;
        if (upd_done) begin
            stat_set[S_UPD] = 1'b1;
            if (mode_q[M_UPD_EN]) stat_set[S_IRQ] = 1'b1;
        end
        if (alarm_hit && mode_q[M_ALM_EN]) begin
            stat_set[S_ALM] = 1'b1;
            stat_set[S_IRQ] = 1'b1;
        end
        if (per_tick && mode_q[M_PER_EN]) begin
            stat_set[S_PER] = 1'b1;
            stat_set[S_IRQ] = 1'b1;
        end
    end

    // Status byte: cleared by a read, new flags always kept
    always_ff @(posedge clk) begin
        if (!rst_n)       stat_q <= RST_STAT;
        else if (sys_clr) stat_q <= '0;
        else              stat_q <= (rd_stat ? '0 : stat_q) | stat_set;
    end

    assign reg_ctla = {busy, ctla_low};
    assign reg_mode = mode_q;
    assign reg_stat = stat_q;
    assign reg_fix  = FIX_VAL;
    assign irq      = stat_q[S_IRQ];

    p_busy_ro_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctla && !upd_start && !upd_done && !wr_mode |=> $stable(reg_ctla[A_BUSY]));
    p_freeze_clears_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mode && wdata[M_FREEZE] |=> !reg_ctla[A_BUSY]);
    p_done_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done && !sys_clr |=> reg_stat[S_UPD]);
    p_done_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done && mode_q[M_UPD_EN] && !sys_clr |=> irq);
    p_alarm_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit && mode_q[M_ALM_EN] && !sys_clr |=> irq && reg_stat[S_ALM]);
    p_tick_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        per_tick && mode_q[M_PER_EN] && !sys_clr |=> irq && reg_stat[S_PER]);
    p_ack_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat && !upd_done && !per_tick |=> reg_stat == '0 && !irq);
    p_sysclr_r12: assert property (@(posedge clk) disable iff (!rst_n)
        sys_clr |=> !irq && !reg_mode[M_PER_EN] && !reg_mode[M_ALM_EN] && !reg_mode[M_SQW_EN]);
endmodule

// File: rtl/rtc_host_regs.sv
// Top: two-location host access to a byte slot space with clock control bytes.
// Assumes single-cycle host strobes and a registered read result one cycle later.
module rtc_host_regs
    import rtc_host_pkg::*;
#(
    parameter int SPACE_BYTES = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_clr,
    input  logic              host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [7:0]        host_wdata,
    input  logic              upd_start,
    input  logic              upd_done,
    input  logic [7:0]        upd_sec,
    input  logic [7:0]        upd_min,
    input  logic [7:0]        upd_hr,
    input  logic              per_tick,
    output logic [7:0]        host_rdata,
    output logic              irq
);
    localparam int IDX_W = $clog2(SPACE_BYTES);

    logic [IDX_W-1:0]  idx;
    slot_sel_t         sel;
    logic              data_wr;
    logic              data_rd;
    logic [DATA_W-1:0] ram_byte;
    logic [2:0][DATA_W-1:0] alarm_bytes;
    logic [2:0][DATA_W-1:0] now_bytes;
    logic              match;
    logic [DATA_W-1:0] reg_ctla, reg_mode, reg_stat, reg_fix;

    assign data_wr   = host_wr && host_addr;
    assign data_rd   = host_rd && host_addr;
    assign now_bytes = {upd_hr, upd_min, upd_sec};

    rtc_host_index #(.IDX_W(IDX_W)) u_index (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx_we (host_wr && !host_addr),
        .idx_in (host_wdata[IDX_W-1:0]),
        .idx    (idx),
        .sel    (sel)
    );

    rtc_host_ram #(.BYTES(SPACE_BYTES), .IDX_W(IDX_W)) u_ram (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (data_wr && sel == SEL_RAM),
        .wr_idx      (idx),
        .wr_data     (host_wdata),
        .ld_en       (upd_done && !reg_mode[M_FREEZE]),
        .ld_sec      (upd_sec),
        .ld_min      (upd_min),
        .ld_hr       (upd_hr),
        .rd_idx      (idx),
        .rd_byte     (ram_byte),
        .alarm_bytes (alarm_bytes)
    );

    rtc_alarm_match #(.FIELDS(3)) u_alarm (
        .alarm (alarm_bytes),
        .now   (now_bytes),
        .hit   (match)
    );

    rtc_host_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sys_clr   (sys_clr),
        .wr_ctla   (data_wr && sel == SEL_CTLA),
        .wr_mode   (data_wr && sel == SEL_MODE),
        .rd_stat   (data_rd && sel == SEL_STAT),
        .wdata     (host_wdata),
        .upd_start (upd_start),
        .upd_done  (upd_done),
        .per_tick  (per_tick),
        .alarm_hit (upd_done && match),
        .reg_ctla  (reg_ctla),
        .reg_mode  (reg_mode),
        .reg_stat  (reg_stat),
        .reg_fix   (reg_fix),
        .irq       (irq)
    );

    // Registered read mux
    always_ff @(posedge clk) begin
        if (!rst_n) host_rdata <= '0;
        else if (host_rd) begin
            if (!host_addr) host_rdata <= IDX_READ;
            else begin
                case (sel)
                    SEL_CTLA: host_rdata <= reg_ctla;
                    SEL_MODE: host_rdata <= reg_mode;
                    SEL_STAT: host_rdata <= reg_stat;
                    SEL_FIX:  host_rdata <= reg_fix;
                    default:  host_rdata <= ram_byte;
                endcase
            end
        end
    end

    p_irq_flag_r14: assert property (@(posedge clk) disable iff (!rst_n)
        irq == reg_stat[S_IRQ]);
    p_idx_read_r13: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && !host_addr |=> host_rdata == IDX_READ);
endmodule

// File: tb/rtc_host_regs_bench.sv
module rtc_host_regs_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sys_clr = 1'b0, host_addr = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic upd_start = 1'b0, upd_done = 1'b0, per_tick = 1'b0;
    logic [7:0] upd_sec = '0, upd_min = '0, upd_hr = '0;
    logic [7:0] host_rdata;
    logic irq;

    int checks = 0;
    int failures = 0;
    logic finished = 1'b0;
    logic [7:0] exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    rtc_host_regs u_rtc_host_regs (
        .clk(clk), .rst_n(rst_n), .sys_clr(sys_clr),
        .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .upd_start(upd_start), .upd_done(upd_done),
        .upd_sec(upd_sec), .upd_min(upd_min), .upd_hr(upd_hr),
        .per_tick(per_tick), .host_rdata(host_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Monitor: compare each read result one edge after its strobe
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (host_rd && exp_q.size() > 0) begin
                chk(tag_q.pop_front(), host_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic strobe_wr(input logic a, input logic [7:0] v);
        @(negedge clk); host_addr = a; host_wr = 1'b1; host_wdata = v;
        @(negedge clk); host_wr = 1'b0;
    endtask

    task automatic reg_wr(input logic [7:0] i, input logic [7:0] v);
        strobe_wr(1'b0, i);
        strobe_wr(1'b1, v);
    endtask

    // Driver: push the expected byte, then issue the read
    task automatic rd_exp(input logic a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp); tag_q.push_back(tag);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk); host_rd = 1'b0;
    endtask

    task automatic reg_rd(input logic [7:0] i, input logic [7:0] exp, input string tag);
        strobe_wr(1'b0, i);
        rd_exp(1'b1, exp, tag);
    endtask

    task automatic go_start();
        @(negedge clk); upd_start = 1'b1;
        @(negedge clk); upd_start = 1'b0;
    endtask

    task automatic go_done(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h);
        @(negedge clk); upd_done = 1'b1; upd_sec = s; upd_min = m; upd_hr = h;
        @(negedge clk); upd_done = 1'b0;
    endtask

    task automatic go_tick();
        @(negedge clk); per_tick = 1'b1;
        @(negedge clk); per_tick = 1'b0;
    endtask

    task automatic go_sysclr();
        @(negedge clk); sys_clr = 1'b1;
        @(negedge clk); sys_clr = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk("R11 irq", {7'd0, irq}, 8'h00);
        reg_rd(8'h0A, 8'h26, "R11 ctla");
        reg_rd(8'h0B, 8'h02, "R11 mode");
        reg_rd(8'h0C, 8'h00, "R11 stat");
        reg_rd(8'h0D, 8'h80, "R11 fix");

        // R2 storage and R1 index masking
        reg_wr(8'h20, 8'h5A);
        reg_rd(8'h20, 8'h5A, "R2 slot20");
        reg_wr(8'h7F, 8'hC3);
        reg_rd(8'h7F, 8'hC3, "R2 slot7f");
        reg_rd(8'hA0, 8'h5A, "R1 index bit7 ignored");
        reg_wr(8'h01, 8'h33);
        reg_rd(8'h01, 8'h33, "R2 alarm slot");
        rd_exp(1'b0, 8'hFF, "R13 even read");

        // R3 busy bit read-only, R5 start/done
        reg_wr(8'h0A, 8'hFF);
        reg_rd(8'h0A, 8'h7F, "R3 busy not written");
        go_start();
        reg_rd(8'h0A, 8'hFF, "R5 busy set");
        reg_wr(8'h0A, 8'h26);
        reg_rd(8'h0A, 8'hA6, "R3 busy kept");
        go_done(8'h10, 8'h20, 8'h08);
        reg_rd(8'h0A, 8'h26, "R5 busy cleared");
        chk("R7 no irq without enable", {7'd0, irq}, 8'h00);
        reg_rd(8'h0C, 8'h10, "R7 update flag");
        rd_exp(1'b1, 8'h00, "R10 stat cleared");
        reg_rd(8'h00, 8'h10, "R6 sec loaded");
        reg_rd(8'h02, 8'h20, "R6 min loaded");
        reg_rd(8'h04, 8'h08, "R6 hr loaded");

        // R4 unwritable bytes
        reg_wr(8'h0C, 8'hFF);
        reg_rd(8'h0C, 8'h00, "R4 stat write ignored");
        reg_wr(8'h0D, 8'h00);
        reg_rd(8'h0D, 8'h80, "R4 fix write ignored");

        // R6 freeze
        go_start();
        reg_wr(8'h0B, 8'h82);
        reg_rd(8'h0A, 8'h26, "R6 freeze clears busy");
        go_start();
        reg_rd(8'h0A, 8'h26, "R6 no busy while frozen");
        go_done(8'h11, 8'h21, 8'h09);
        reg_rd(8'h00, 8'h10, "R6 sec frozen");
        reg_rd(8'h04, 8'h08, "R6 hr frozen");
        reg_rd(8'h0C, 8'h10, "R7 flag while frozen");
        reg_wr(8'h0B, 8'h02);

        // R7 update interrupt
        reg_wr(8'h0B, 8'h12);
        go_done(8'h12, 8'h22, 8'h0A);
        chk("R7 irq raised", {7'd0, irq}, 8'h01);
        reg_rd(8'h0C, 8'h90, "R7 irq flag");
        chk("R10 irq lowered", {7'd0, irq}, 8'h00);

        // R8 alarm
        reg_wr(8'h01, 8'hC0);
        reg_wr(8'h03, 8'h30);
        reg_wr(8'h05, 8'h12);
        reg_wr(8'h0B, 8'h22);
        go_done(8'h45, 8'h30, 8'h12);
        chk("R8 alarm irq", {7'd0, irq}, 8'h01);
        reg_rd(8'h0C, 8'hB0, "R8 alarm flags");
        go_done(8'h45, 8'h31, 8'h12);
        chk("R8 mismatch no irq", {7'd0, irq}, 8'h00);
        reg_rd(8'h0C, 8'h10, "R8 mismatch flags");
        reg_wr(8'h0B, 8'h02);
        go_done(8'h45, 8'h30, 8'h12);
        reg_rd(8'h0C, 8'h10, "R8 disabled flags");

        // R9 periodic
        go_tick();
        chk("R9 tick disabled", {7'd0, irq}, 8'h00);
        reg_rd(8'h0C, 8'h00, "R9 tick disabled flags");
        reg_wr(8'h0B, 8'h42);
        go_tick();
        chk("R9 tick irq", {7'd0, irq}, 8'h01);
        reg_rd(8'h0C, 8'hC0, "R9 tick flags");

        // R12 system clear
        reg_wr(8'h0B, 8'h6A);
        go_tick();
        chk("R12 irq before", {7'd0, irq}, 8'h01);
        go_sysclr();
        chk("R12 irq lowered", {7'd0, irq}, 8'h00);
        reg_rd(8'h0B, 8'h02, "R12 enables cleared");
        reg_rd(8'h0C, 8'h00, "R12 stat cleared");
        reg_rd(8'h20, 8'h5A, "R12 storage kept");
        reg_rd(8'h0A, 8'h26, "R12 ctla kept");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) chk("scoreboard drained", 8'(exp_q.size()), 8'h00);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5 * 200000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule